// File: doc/BRIEF.md
# Second-Order Requantising Noise Shaper

This block turns a stream of 16-bit two's-complement samples, taken after interpolation, into 12-bit two's-complement codes for a converter core. It works at the output sample rate and takes one sample in each cycle where `in_valid` is high. When shaping is on, the four low bits that are dropped at each step are kept as a signed error. The last two errors are fed back through the filter (1 - z^-1)^2. This moves the requantisation noise up toward the top of the band and away from the wanted signal. When shaping is off, the block rounds each sample to the nearest code.

A two-state mode machine controls the run-time enable. In state `MODE_ROUND`, samples are rounded and both error registers are held at zero. In state `MODE_SHAPE`, samples take the feedback path. The machine has two transitions. `ENTER_SHAPE` goes from `MODE_ROUND` to `MODE_SHAPE` when `shape_en` is high at a clock edge. `LEAVE_SHAPE` goes from `MODE_SHAPE` to `MODE_ROUND` when `shape_en` is low at a clock edge. In both states, a high `shape_en` keeps shaping on and a low `shape_en` keeps rounding on. A sample is processed in the mode the machine holds during its cycle, so a change of enable acts on the samples of the following cycle. The result is saturated to the 12-bit range and registered.

Top module: `ns2_requantizer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_valid`, `out_code` and both error registers, and puts the mode machine in `MODE_ROUND`.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: In a cycle with `in_valid` low, `out_code` keeps its previous value.
- R4: In `MODE_ROUND`, a sample x gives the output floor((x + 8) / 16), saturated to the range -2048..2047 in two's complement.
- R5: In `MODE_SHAPE`, with e1 as the newest stored error and e2 as the one before it, the sample x forms v = x - 2*e1 + e2. The output is floor(v / 16), saturated to -2048..2047. The new error is out*16 - v, and this becomes e1 while the old e1 becomes e2.
- R6: The error registers change only on valid samples processed in `MODE_SHAPE`. Idle cycles with `in_valid` low leave them unchanged.
- R7: When saturation occurs, the stored error is clamped to the range -15..0. A run of full-scale positive input therefore stays at 2047 and does not wind up the feedback.
- R8: Any clock edge with `shape_en` low clears both error registers, so shaping that is switched back on starts from zero error.
- R9: `shape_en` is sampled at the clock edge. A sample that arrives in the same cycle that shaping is first enabled is still rounded, and shaping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| shape_en | input | 1 | 1 selects error-feedback shaping, 0 selects rounding |
| in_valid | input | 1 | Strobe that marks a sample on `in_data` |
| in_data | input | 16 | Sample, two's complement |
| out_valid | output | 1 | Registered strobe for `out_code` |
| out_code | output | 12 | Converter code, two's complement |

## Verification
A wrong error value does not show up in the sample that caused it. It appears in the code of the next valid sample, and again in the one after, because the error is weighted by -2 and then +1. It can also be hidden when both codes round to the same value, so the bench uses long runs of random data and small-amplitude input levels that keep the output close to a code boundary. A mode machine that is one cycle late, or an error that is not cleared on disable, shows as a difference of one or two codes in the first few samples after an enable edge. A faulty clamp shows in the codes that follow a full-scale burst, because the fed-back error pulls them away from the value expected.

// File: rtl/ns_pkg.sv
package ns_pkg;

    typedef enum logic {
        MODE_ROUND = 1'b0,
        MODE_SHAPE = 1'b1
    } ns_mode_e;

endpackage

// File: rtl/ns_mode_fsm.sv
module ns_mode_fsm
    import ns_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shape_en,
    output ns_mode_e mode_q,
    output logic     shape_active,
    output logic     err_clr
);

    ns_mode_e mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ROUND;
        end else begin
            mode_q <= mode_d;
        end
    end

    // ENTER_SHAPE / LEAVE_SHAPE transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ROUND: if (shape_en)  mode_d = MODE_SHAPE;
            MODE_SHAPE: if (!shape_en) mode_d = MODE_ROUND;
            default:                   mode_d = MODE_ROUND;
        endcase
    end

    // outputs
    always_comb begin
        shape_active = 1'b0;
        err_clr      = 1'b0;
        unique case (mode_q)
            MODE_ROUND: begin
                shape_active = 1'b0;
                err_clr      = (mode_d == MODE_ROUND);
            end
            MODE_SHAPE: begin
                shape_active = 1'b1;
                err_clr      = (mode_d == MODE_ROUND);
            end
            default: begin
                shape_active = 1'b0;
                err_clr      = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ns_err_store.sv
module ns_err_store #(
    parameter int ERR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load,
    input  logic signed [ERR_W-1:0] err_new,
    output logic signed [ERR_W-1:0] err1,
    output logic signed [ERR_W-1:0] err2
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err1 <= '0;
            err2 <= '0;
        end else if (load) begin
            err2 <= err1;
            err1 <= err_new;
        end
    end

endmodule

// File: rtl/ns_requant.sv
module ns_requant #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]                 sample,
    input  logic                            shape,
    input  logic signed [IN_W-OUT_W:0]      err1,
    input  logic signed [IN_W-OUT_W:0]      err2,
    output logic [OUT_W-1:0]                code,
    output logic signed [IN_W-OUT_W:0]      err_new
);

    localparam int DROP  = IN_W - OUT_W;
    localparam int ERR_W = DROP + 1;
    localparam int SUM_W = IN_W + 2;
    localparam int QW    = SUM_W - DROP;

    localparam logic signed [QW-1:0]    Q_MAX   = QW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [QW-1:0]    Q_MIN   = QW'(-(1 << (OUT_W - 1)));
    localparam logic signed [SUM_W-1:0] HALF    = SUM_W'(1 << (DROP - 1));
    localparam logic signed [SUM_W-1:0] ERR_LO  = SUM_W'(-((1 << DROP) - 1));

    logic signed [SUM_W-1:0] x_ext, e1_ext, e2_ext;
    logic signed [SUM_W-1:0] shaped, rounded, pick;
    logic signed [QW-1:0]    q_raw, q_sat;
    logic signed [SUM_W-1:0] back, e_raw;

    always_comb begin
        x_ext   = {{(SUM_W-IN_W){sample[IN_W-1]}}, sample};
        e1_ext  = {{(SUM_W-ERR_W){err1[ERR_W-1]}}, err1};
        e2_ext  = {{(SUM_W-ERR_W){err2[ERR_W-1]}}, err2};
        shaped  = x_ext - (e1_ext <<< 1) + e2_ext;
        rounded = x_ext + HALF;
        pick    = shape ? shaped : rounded;
        q_raw   = pick[SUM_W-1:DROP];
    end

    always_comb begin
        if (q_raw > Q_MAX) begin
            q_sat = Q_MAX;
        end else if (q_raw < Q_MIN) begin
            q_sat = Q_MIN;
        end else begin
            q_sat = q_raw;
        end
        code = q_sat[OUT_W-1:0];
    end

    always_comb begin
        back  = {q_sat, {DROP{1'b0}}};
        e_raw = back - shaped;
        if (e_raw > 0) begin
            err_new = '0;
        end else if (e_raw < ERR_LO) begin
            err_new = ERR_LO[ERR_W-1:0];
        end else begin
            err_new = e_raw[ERR_W-1:0];
        end
    end

endmodule

// File: rtl/ns2_requantizer.sv
module ns2_requantizer #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shape_en,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code
);

    localparam int DROP  = IN_W - OUT_W;
    localparam int ERR_W = DROP + 1;

    ns_pkg::ns_mode_e        mode_q;
    logic                    shape_active;
    logic                    err_clr;
    logic signed [ERR_W-1:0] err1, err2, err_new;
    logic [OUT_W-1:0]        code_next;

    ns_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .shape_en     (shape_en),
        .mode_q       (mode_q),
        .shape_active (shape_active),
        .err_clr      (err_clr)
    );

    ns_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
        .sample  (in_data),
        .shape   (shape_active),
        .err1    (err1),
        .err2    (err2),
        .code    (code_next),
        .err_new (err_new)
    );

    ns_err_store #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst     (rst),
        .clr     (err_clr),
        .load    (in_valid && shape_active),
        .err_new (err_new),
        .err1    (err1),
        .err2    (err2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_code <= code_next;
            end
        end
    end

endmodule

// File: rtl/ns2_requantizer_chk.sv
module ns2_requantizer_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        shape_en,
    input logic                        in_valid,
    input logic [IN_W-1:0]             in_data,
    input logic                        out_valid,
    input logic [OUT_W-1:0]            out_code,
    input ns_pkg::ns_mode_e            mode,
    input logic signed [IN_W-OUT_W:0]  err1,
    input logic signed [IN_W-OUT_W:0]  err2
);

    localparam int DROP = IN_W - OUT_W;

    function automatic logic [OUT_W-1:0] round_code(input logic [IN_W-1:0] d);
        int x;
        int q;
        x = int'($signed(d));
        q = (x + (1 << (DROP - 1))) >>> DROP;
        if (q > (1 << (OUT_W - 1)) - 1) q = (1 << (OUT_W - 1)) - 1;
        if (q < -(1 << (OUT_W - 1)))    q = -(1 << (OUT_W - 1));
        return q[OUT_W-1:0];
    endfunction

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_code));

    // R4
    round_path_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == ns_pkg::MODE_ROUND) |=> out_code == round_code($past(in_data)));

    // R7
    err_range_chk: assert property (@(posedge clk) disable iff (rst)
        (err1 <= 0) && (err1 >= -((1 << DROP) - 1)) && (err2 <= 0) && (err2 >= -((1 << DROP) - 1)));

    // R8
    err_zero_round_chk: assert property (@(posedge clk) disable iff (rst)
        mode == ns_pkg::MODE_ROUND |-> (err1 == 0 && err2 == 0));

    // R9
    mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
        shape_en |=> mode == ns_pkg::MODE_SHAPE);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && shape_en) |=> ($stable(err1) && $stable(err2)));

endmodule

bind ns2_requantizer ns2_requantizer_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shape_en  (shape_en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_code  (out_code),
    .mode      (mode_q),
    .err1      (err1),
    .err2      (err2)
);

// File: tb/tb_ns2_requantizer.sv
`timescale 1ns/1ps
module tb_ns2_requantizer;

    logic        clk = 1'b0;
    logic        rst;
    logic        shape_en;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [11:0] out_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    bit m_shape;
    int m_e1, m_e2, m_last;

    always #4 clk = ~clk;

    ns2_requantizer dut (
        .clk       (clk),
        .rst       (rst),
        .shape_en  (shape_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic int sat12(input int q);
        if (q > 2047)  return 2047;
        if (q < -2048) return -2048;
        return q;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model after posedge, check at next negedge
    task automatic step(input bit v, input int x, input bit en, input string tag);
        int exp_v;
        int y;
        int e;
        string t;
        bit used_shape;
        in_valid = v;
        in_data  = 16'(x);
        shape_en = en;
        @(posedge clk);
        used_shape = m_shape;
        if (v) begin
            if (m_shape) begin
                exp_v = x - 2 * m_e1 + m_e2;
                y = sat12(exp_v >>> 4);
                e = y * 16 - exp_v;
                if (e > 0)   e = 0;
                if (e < -15) e = -15;
            end else begin
                y = sat12((x + 8) >>> 4);
                e = 0;
            end
            m_last = y;
        end
        if (!en) begin
            m_e1 = 0;
            m_e2 = 0;
        end else if (v && m_shape) begin
            m_e2 = m_e1;
            m_e1 = e;
        end
        m_shape = en;
        @(negedge clk);
        check("R2", int'(out_valid), int'(v));
        t = tag;
        if (t == "") t = v ? (used_shape ? "R5" : "R4") : "R3";
        check(t, int'($signed(out_code)), m_last);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        int x;
        bit en;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst = 1'b1; shape_en = 1'b0; in_valid = 1'b0; in_data = '0;
        m_shape = 0; m_e1 = 0; m_e2 = 0; m_last = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_code), 0);
        rst = 1'b0;

        // R4: rounding corners
        step(1, 32767, 0, "R4");
        step(1, -32768, 0, "R4");
        step(1, 7, 0, "R4");
        step(1, 8, 0, "R4");
        step(1, -9, 0, "R4");
        step(0, 1234, 0, "R3");

        // R9: enable with a sample in the same cycle -> still rounded
        step(1, 5, 1, "R9");
        // R5: small DC level, shaped from zero error
        for (int i = 0; i < 12; i++) step(1, 5, 1, "R5");
        // R6: idle cycles leave error, then continue
        step(0, -20000, 1, "R6");
        step(0, 9999, 1, "R6");
        for (int i = 0; i < 4; i++) step(1, 5, 1, "R6");

        // R7: full-scale burst, clamp, then back to small input
        for (int i = 0; i < 6; i++) step(1, 32767, 1, "R7");
        for (int i = 0; i < 4; i++) step(1, 3, 1, "R7");
        for (int i = 0; i < 4; i++) step(1, -32768, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, -3, 1, "R7");

        // R8: disable for one idle cycle, re-enable, shaped from zero
        step(0, 0, 0, "R8");
        step(0, 0, 1, "R8");
        for (int i = 0; i < 6; i++) step(1, 11, 1, "R8");

        // random phase
        en = 1;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) en = ~en;
            case ($urandom % 3)
                0:       x = int'($signed(16'($urandom)));
                1:       x = int'($urandom % 64) - 32;
                default: x = ($urandom % 2) ? 32767 - int'($urandom % 40) : -32768 + int'($urandom % 40);
            endcase
            step(($urandom % 4) != 0, x, en, "");
        end

        // R1: reset mid-stream clears state
        shape_en = 1; in_valid = 1; in_data = 16'd100;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 0;
        m_shape = 0; m_e1 = 0; m_e2 = 0; m_last = 0;
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_code), 0);
        step(1, 100, 1, "R1");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule